// File: doc/BRIEF.md
# Programmable Sync Delay Generator

This block rebuilds the horizontal and vertical sync pulses for a pixel stream after it has passed through a processing pipeline with fixed line and clock latency. Downstream logic uses the outputs as the sync pulses of the delayed stream. The pixel data path is not part of this block. Only sync timing is produced here.

A mode input picks one of two ways to place the outputs. In data-aligned mode, the output line sync follows a first-pixel strobe from the pipeline. The output frame sync marks the first such strobe after each frame sync. In counter mode, the output line sync is placed a programmed number of clocks after each input line sync. The output frame sync rides on the output line sync of a line that comes a programmed number of lines after the input frame sync.

In counter mode the clock delay is limited by the input format. The line delay, the clock delay and the format are captured on each input frame sync.

Top module: `sync_delay_gen`

## Requirements
- R1: With `mode`=0, `hd_out` follows `first_pix` on the same clock. `hd_in` has no effect on `hd_out` in this mode.
- R2: With `mode`=0, `vd_out` is high only with the first `first_pix` strobe that occurs on or after the clock where `vd_in` rises. Later strobes in the same frame leave `vd_out` low.
- R3: With `mode`=1, let the first rising clock edge that samples `hd_in` high be edge 1. `hd_out` is then high for one clock, after edge D+1, where D is the effective clock delay.
- R4: With `mode`=1, count the `hd_in` rising edges starting at the edge where `vd_in` rises. An `hd_in` rise on that same edge counts as the first. `vd_out` is high together with the `hd_out` pulse generated for rise number L+1, where L is `line_dly`. `vd_out` is never high without `hd_out`.
- R5: `line_dly`, `clk_dly` and `fmt` are captured on the clock where `vd_in` rises. Changes to them between frame syncs do not affect timing until the next `vd_in` rise.
- R6: The effective clock delay is `clk_dly` clamped to at most 8 when `fmt`=1 (16-bit YCbCr). For `fmt`=0 (raw), 2 (8-bit YCbCr) or 3, it is clamped to at most 16.
- R7: Each output pulse lasts one clock. Holding `hd_in` high gives a single `hd_out` pulse.
- R8: A new `vd_in` rise while a line count is still pending restarts the count from `line_dly`, and the earlier count is dropped.
- R9: While `rst` is high, with `mode`=1 and `first_pix` low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_in | input | 1 | Input line sync, active high |
| vd_in | input | 1 | Input frame sync, active high |
| first_pix | input | 1 | Strobe from the pipeline marking the first output pixel of a line |
| mode | input | 1 | 0: data-aligned syncs, 1: counter-delayed syncs |
| line_dly | input | 8 | Line delay from input frame sync to output frame sync |
| clk_dly | input | 8 | Clock delay from input line sync to output line sync |
| fmt | input | 2 | Input format: 0 raw, 1 16-bit YCbCr, 2 8-bit YCbCr, 3 treated as raw |
| hd_out | output | 1 | Regenerated line sync |
| vd_out | output | 1 | Regenerated frame sync |

## Verification
Some properties are checked by assertions on every cycle:
- `vd_out` never appears without `hd_out`.
- The captured clock delay never exceeds the cap for the captured format.
- The pending clock counter stays in range.
- A frame sync re-arms the line count.
- A first-pixel strobe disarms the data-aligned frame marker.

Other behaviour only the bench scenarios can show: the exact latency for each format and delay value, which line carries the frame sync, the restart of the line count after a second frame sync, and that settings changed mid-frame are ignored.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    localparam int DLY_W      = 8;
    localparam int CAP_WIDE   = 16;
    localparam int CAP_NARROW = 8;

    typedef enum logic [1:0] {
        FMT_RAW  = 2'd0,
        FMT_YC16 = 2'd1,
        FMT_YC8  = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [DLY_W-1:0] line_dly;
        logic [DLY_W-1:0] clk_dly;
    } dly_cfg_t;

    function automatic logic [DLY_W-1:0] clamp_dly(input fmt_e f, input logic [DLY_W-1:0] d);
        logic [DLY_W-1:0] cap;
        cap = (f == FMT_YC16) ? DLY_W'(CAP_NARROW) : DLY_W'(CAP_WIDE);
        return (d > cap) ? cap : d;
    endfunction
endpackage

// File: rtl/sdg_edge_det.sv
module sdg_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= '0;
        else     sig_q <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = sig[i] & ~sig_q[i];
    end
endmodule

// File: rtl/sdg_cfg_latch.sv
module sdg_cfg_latch
    import sdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vd_rise,
    input  logic [1:0]       fmt,
    input  logic [DLY_W-1:0] line_dly,
    input  logic [DLY_W-1:0] clk_dly,
    output dly_cfg_t         cfg_eff
);
    dly_cfg_t cfg_q;
    logic     narrow_q;
    dly_cfg_t cfg_new;

    always_comb begin
        cfg_new.line_dly = line_dly;
        cfg_new.clk_dly  = clamp_dly(fmt_e'(fmt), clk_dly);
        cfg_eff          = vd_rise ? cfg_new : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            narrow_q <= 1'b0;
        end else if (vd_rise) begin
            cfg_q    <= cfg_new;
            narrow_q <= (fmt_e'(fmt) == FMT_YC16);
        end
    end

    p_cap_wide_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_q.clk_dly <= DLY_W'(CAP_WIDE));
    p_cap_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        narrow_q |-> cfg_q.clk_dly <= DLY_W'(CAP_NARROW));
endmodule

// File: rtl/sdg_frame_tracker.sv
module sdg_frame_tracker
    import sdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vd_rise,
    input  logic             hd_rise,
    input  logic             first_pix,
    input  logic [DLY_W-1:0] line_dly,
    output logic             vd_tag,
    output logic             frame_first
);
    logic [DLY_W-1:0] vcnt;
    logic             vpend;
    logic             armed;
    logic [DLY_W-1:0] cnt_eff;
    logic             pend_eff;
    logic             armed_eff;

    always_comb begin
        cnt_eff     = vd_rise ? line_dly : vcnt;
        pend_eff    = vd_rise | vpend;
        vd_tag      = hd_rise & pend_eff & (cnt_eff == '0);
        armed_eff   = armed | vd_rise;
        frame_first = first_pix & armed_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt  <= '0;
            vpend <= 1'b0;
            armed <= 1'b0;
        end else begin
            armed <= armed_eff & ~first_pix;
            if (hd_rise && pend_eff) begin
                if (cnt_eff == '0) begin
                    vpend <= 1'b0;
                end else begin
                    vpend <= 1'b1;
                    vcnt  <= cnt_eff - 1'b1;
                end
            end else if (vd_rise) begin
                vpend <= 1'b1;
                vcnt  <= line_dly;
            end
        end
    end

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (vd_rise && !hd_rise) |=> (vpend && vcnt == $past(line_dly)));
    p_disarm_r2: assert property (@(posedge clk) disable iff (rst)
        first_pix |=> !armed);
endmodule

// File: rtl/sdg_line_timer.sv
module sdg_line_timer
    import sdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hd_rise,
    input  logic             vd_tag,
    input  logic [DLY_W-1:0] clk_dly,
    output logic             hd_pulse,
    output logic             vd_pulse
);
    logic [DLY_W-1:0] hcnt;
    logic             hpend;
    logic             tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt     <= '0;
            hpend    <= 1'b0;
            tag_q    <= 1'b0;
            hd_pulse <= 1'b0;
            vd_pulse <= 1'b0;
        end else begin
            hd_pulse <= 1'b0;
            vd_pulse <= 1'b0;
            if (hd_rise) begin
                if (clk_dly == '0) begin
                    hd_pulse <= 1'b1;
                    vd_pulse <= vd_tag;
                    hpend    <= 1'b0;
                end else begin
                    hpend <= 1'b1;
                    hcnt  <= clk_dly - 1'b1;
                    tag_q <= vd_tag;
                end
            end else if (hpend) begin
                if (hcnt == '0) begin
                    hd_pulse <= 1'b1;
                    vd_pulse <= tag_q;
                    hpend    <= 1'b0;
                end else begin
                    hcnt <= hcnt - 1'b1;
                end
            end
        end
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        hpend |-> hcnt < DLY_W'(CAP_WIDE));
    p_pend_fires_r3: assert property (@(posedge clk) disable iff (rst)
        (hpend && hcnt == '0 && !hd_rise) |=> hd_pulse);
endmodule

// File: rtl/sync_delay_gen.sv
module sync_delay_gen
    import sdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hd_in,
    input  logic             vd_in,
    input  logic             first_pix,
    input  logic             mode,
    input  logic [DLY_W-1:0] line_dly,
    input  logic [DLY_W-1:0] clk_dly,
    input  logic [1:0]       fmt,
    output logic             hd_out,
    output logic             vd_out
);
    logic [1:0] rise;
    logic       vd_rise;
    logic       hd_rise;
    dly_cfg_t   cfg;
    logic       vd_tag;
    logic       frame_first;
    logic       hd_pulse;
    logic       vd_pulse;

    sdg_edge_det #(.W(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({vd_in, hd_in}),
        .rise (rise)
    );
    assign vd_rise = rise[1];
    assign hd_rise = rise[0];

    sdg_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .vd_rise  (vd_rise),
        .fmt      (fmt),
        .line_dly (line_dly),
        .clk_dly  (clk_dly),
        .cfg_eff  (cfg)
    );

    sdg_frame_tracker u_frame (
        .clk         (clk),
        .rst         (rst),
        .vd_rise     (vd_rise),
        .hd_rise     (hd_rise),
        .first_pix   (first_pix),
        .line_dly    (cfg.line_dly),
        .vd_tag      (vd_tag),
        .frame_first (frame_first)
    );

    sdg_line_timer u_line (
        .clk      (clk),
        .rst      (rst),
        .hd_rise  (hd_rise),
        .vd_tag   (vd_tag),
        .clk_dly  (cfg.clk_dly),
        .hd_pulse (hd_pulse),
        .vd_pulse (vd_pulse)
    );

    assign hd_out = mode ? hd_pulse : first_pix;
    assign vd_out = mode ? vd_pulse : frame_first;

    p_vd_on_hd_r4: assert property (@(posedge clk) disable iff (rst)
        vd_out |-> hd_out);
endmodule

// File: tb/sync_delay_gen_bench.sv
module sync_delay_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hd_in = 1'b0, vd_in = 1'b0, first_pix = 1'b0, mode = 1'b1;
    logic [7:0] line_dly = '0, clk_dly = '0;
    logic [1:0] fmt = '0;
    logic       hd_out, vd_out;

    int errors = 0, checks = 0;
    int hp = 0, vc = 0, vi = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sync_delay_gen u_sync_delay_gen (
        .clk(clk), .rst(rst), .hd_in(hd_in), .vd_in(vd_in), .first_pix(first_pix),
        .mode(mode), .line_dly(line_dly), .clk_dly(clk_dly), .fmt(fmt),
        .hd_out(hd_out), .vd_out(vd_out)
    );

    // {fmt, clk_dly, expected edge index of hd_out}
    localparam logic [15:0] VEC [9] = '{
        {2'd0, 8'd0,   6'd1},
        {2'd0, 8'd5,   6'd6},
        {2'd0, 8'd16,  6'd17},
        {2'd0, 8'd40,  6'd17},
        {2'd1, 8'd8,   6'd9},
        {2'd1, 8'd9,   6'd9},
        {2'd1, 8'd200, 6'd9},
        {2'd2, 8'd20,  6'd17},
        {2'd3, 8'd3,   6'd4}
    };

    task automatic tick();
        @(posedge clk);
        #1;
        if (hd_out) hp++;
        if (vd_out) begin vc++; vi = hp; end
    endtask

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame_sync();
        vd_in = 1'b1; tick(); vd_in = 1'b0; tick();
    endtask

    task automatic measure(input int exp, input string req);
        int lat = 0;
        hd_in = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (k == 1) hd_in = 1'b0;
            if (hd_out && lat == 0) lat = k;
        end
        chk(lat, exp, req);
    endtask

    task automatic line_pulse(input int gap);
        hd_in = 1'b1; tick(); hd_in = 1'b0;
        repeat (gap) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) tick();
        chk(hd_out, 0, "R9 hd_out in reset");
        chk(vd_out, 0, "R9 vd_out in reset");
        rst = 1'b0;
        tick();

        // R3 R6 table walk
        for (int i = 0; i < 9; i++) begin
            fmt = VEC[i][15:14];
            clk_dly = VEC[i][13:6];
            frame_sync();
            measure(int'(VEC[i][5:0]), $sformatf("R3/R6 vector %0d", i));
        end

        // R5 mid-frame change ignored until next frame sync
        fmt = 2'd0; clk_dly = 8'd2; frame_sync();
        clk_dly = 8'd10;
        measure(3, "R5 mid-frame clk_dly ignored");
        frame_sync();
        measure(11, "R5 new clk_dly after frame sync");

        // R7 held hd_in gives one pulse
        clk_dly = 8'd0; frame_sync();
        hp = 0;
        hd_in = 1'b1;
        repeat (20) tick();
        hd_in = 1'b0;
        repeat (10) tick();
        chk(hp, 1, "R7 single hd_out pulse");

        // R4 line delay with coincident first line
        clk_dly = 8'd3; line_dly = 8'd2;
        repeat (5) tick();
        hp = 0; vc = 0; vi = 0;
        vd_in = 1'b1; hd_in = 1'b1; tick(); vd_in = 1'b0; hd_in = 1'b0;
        repeat (9) tick();
        line_pulse(9);
        line_pulse(9);
        repeat (10) tick();
        chk(hp, 3, "R4 hd_out pulse count");
        chk(vc, 1, "R4 vd_out pulse count");
        chk(vi, 3, "R4 vd_out on third line");

        // R8 restart on a new frame sync
        line_dly = 8'd3;
        hp = 0; vc = 0; vi = 0;
        frame_sync();
        line_pulse(9);
        line_pulse(9);
        frame_sync();
        for (int j = 0; j < 4; j++) line_pulse(9);
        repeat (10) tick();
        chk(vc, 1, "R8 single vd_out after restart");
        chk(vi, 6, "R8 vd_out on fourth line after restart");

        // R1 R2 data-aligned mode
        mode = 1'b0;
        hd_in = 1'b1; #1;
        chk(hd_out, 0, "R1 hd_in ignored in mode 0");
        tick(); hd_in = 1'b0;
        repeat (20) tick();
        chk(hd_out, 0, "R1 no hd_out without strobe");
        frame_sync();
        repeat (3) tick();
        first_pix = 1'b1; #1;
        chk(hd_out, 1, "R1 hd_out with strobe");
        chk(vd_out, 1, "R2 vd_out on first strobe of frame");
        tick(); first_pix = 1'b0; #1;
        chk(hd_out, 0, "R1 hd_out follows strobe low");
        repeat (4) tick();
        first_pix = 1'b1; #1;
        chk(hd_out, 1, "R1 hd_out on later strobe");
        chk(vd_out, 0, "R2 no vd_out on later strobe");
        tick(); first_pix = 1'b0;
        vd_in = 1'b1; first_pix = 1'b1; #1;
        chk(vd_out, 1, "R2 vd_out when strobe meets frame sync");
        tick(); vd_in = 1'b0; first_pix = 1'b0;
        tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule